// File: doc/BRIEF.md
# Vector Length Control Update Unit

This block turns a 12-bit vector-length control field, taken from an instruction prefix, into updates of two architectural registers. The first, the length ceiling (MAXVL), is the largest vector length allowed. The second, the active length (VL), is the number of elements the following vector operations process. When the field asks for it, the block also returns the resulting active length to a scalar register, so that software can use the granted length in a loop.

The field packs four parts:

- **Mode bit (bit 11).** It selects loop mode or one-off mode.
- **Destination index (bits 10:6).** This is the scalar register that receives the result.
- **Length part (bits 5:1).** In one-off mode it is an immediate. In loop mode it is an immediate or a scalar register index.
- **Flag bit (bit 0).**

In loop mode, the flag bit chooses where the requested length comes from. It is either the immediate plus one, or the value of the scalar register named by the length part. The active length becomes the smaller of the request and the current ceiling.

In one-off mode, the flag bit chooses between two updates. With the flag at 0, the ceiling and the active length are both set to the immediate plus one. With the flag at 1, only the ceiling is set to the immediate plus one, and the active length is pulled down to the new ceiling if it no longer fits. A field of all zeros is a legal no-op.

The register-file read address is driven from the length part every cycle, and the read data is expected back in the same cycle. The scalar write request is combinational in the strobe cycle. Both length registers take their new values at the clock edge that closes that cycle.

Top module: `vl_ctrl_unit`

## Requirements
- R1: After reset the ceiling and the active length both read 1, and the scalar write enable is low.
- R2: A strobed field of all zeros changes neither length register and raises no scalar write.
- R3: One-off mode (bit 11 = 1) with bit 0 = 0 sets both the ceiling and the active length to imm+1, where imm is bits 5:1. The range is therefore 1 to 32.
- R4: One-off mode with bit 0 = 1 sets the ceiling to imm+1. The active length keeps its old value when that value is at most the new ceiling, and otherwise takes the new ceiling.
- R5: Loop mode (bit 11 = 0) with bit 0 = 1 requests imm+1. The active length becomes min(imm+1, ceiling) and the ceiling is unchanged.
- R6: Loop mode with bit 0 = 0 and a nonzero field drives bits 5:1 onto the read address. The active length becomes min(read value, ceiling), compared over the full register width, and the ceiling is unchanged.
- R7: For a strobed nonzero field whose destination index (bits 10:6) is not zero, the scalar write enable is high in the strobe cycle. The write address is the destination index, and the write data is the new active length, zero-extended.
- R8: A destination index of zero suppresses the scalar write, while the length registers still update.
- R9: With the strobe low, no register changes and the write enable stays low, whatever the field holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Strobe marking a field to act on this cycle |
| vl_field | input | 12 | Vector-length control field |
| src_rdata | input | XLEN | Scalar register read value used in loop register mode |
| src_addr | output | 5 | Scalar register read index, bits 5:1 of the field |
| maxvl | output | 6 | Current length ceiling |
| vl | output | 6 | Current active length |
| wr_en | output | 1 | Scalar write enable |
| wr_addr | output | 5 | Scalar write index |
| wr_data | output | XLEN | Scalar write data, the new active length zero-extended |

## Verification
The corner cases come first.

- **Clamping in both directions.** A loop request above the ceiling is tried with an immediate of 31, which requests 32. A design that skips the minimum would hand out a length the ceiling forbids.
- **Register requests with high bits set.** A register value of 300 is requested, which lies above the ceiling but whose low six bits read 44. A design that compares only the low bits would grant 44.
- **Ceiling-only updates.** These are tried both shrinking and growing the ceiling. A wrong design would either leave an oversized active length or needlessly overwrite a smaller one.
- **The all-zero field, destination zero, a dropped strobe and a zero register read.** The all-zero field would otherwise decode as a register request of x0. Each of these cases catches stray writes or spurious updates.

// File: rtl/vlc_pkg.sv
package vlc_pkg;

  localparam int FIELD_W = 12;
  localparam int IDX_W   = 5;
  localparam int IMM_W   = 5;
  localparam int LEN_W   = IMM_W + 1;

  localparam int MODE_BIT = FIELD_W - 1;
  localparam int DEST_HI  = MODE_BIT - 1;
  localparam int DEST_LO  = DEST_HI - IDX_W + 1;
  localparam int IMM_HI   = DEST_LO - 1;
  localparam int IMM_LO   = 1;
  localparam int FLAG_BIT = 0;

  typedef enum logic [2:0] {
    OP_NONE     = 3'd0,
    OP_LOOP_IMM = 3'd1,
    OP_LOOP_REG = 3'd2,
    OP_SET_BOTH = 3'd3,
    OP_SET_MAX  = 3'd4
  } vl_op_e;

  typedef struct packed {
    vl_op_e           op;
    logic [IDX_W-1:0] dest;
    logic [IMM_W-1:0] imm;
  } vl_cmd_t;

  // Immediate is stored biased by one: code 0 means length 1.
  function automatic logic [LEN_W-1:0] imm_to_len(input logic [IMM_W-1:0] imm);
    return {1'b0, imm} + LEN_W'(1);
  endfunction

  // Smaller of a requested length and a cap.
  function automatic logic [LEN_W-1:0] min_len(input logic [LEN_W-1:0] req,
                                               input logic [LEN_W-1:0] cap);
    return (req > cap) ? cap : req;
  endfunction

endpackage

// File: rtl/vlc_decode.sv
module vlc_decode
  import vlc_pkg::*;
(
  input  logic               valid,
  input  logic [FIELD_W-1:0] field,
  output vl_cmd_t            cmd,
  output logic               is_noop
);

  logic mode_one_off;
  logic flag;

  assign mode_one_off = field[MODE_BIT];
  assign flag         = field[FLAG_BIT];
  assign is_noop      = (field == '0);

  always_comb begin
    cmd.dest = field[DEST_HI:DEST_LO];
    cmd.imm  = field[IMM_HI:IMM_LO];
    if (!valid || is_noop) begin
      cmd.op = OP_NONE;
    end else if (mode_one_off) begin
      cmd.op = flag ? OP_SET_MAX : OP_SET_BOTH;
    end else begin
      cmd.op = flag ? OP_LOOP_IMM : OP_LOOP_REG;
    end
  end

endmodule

// File: rtl/vlc_next.sv
module vlc_next
  import vlc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  vl_op_e           op,
  input  logic [IMM_W-1:0] imm,
  input  logic [LEN_W-1:0] cur_max,
  input  logic [LEN_W-1:0] cur_vl,
  input  logic [XLEN-1:0]  src_rdata,
  output logic [LEN_W-1:0] nxt_max,
  output logic [LEN_W-1:0] nxt_vl,
  output logic             upd
);

  localparam int PAD_W = XLEN - LEN_W;

  logic [LEN_W-1:0] imm_len;
  logic [XLEN-1:0]  cap_wide;
  logic             reg_over;
  logic [LEN_W-1:0] reg_len;

  assign imm_len  = imm_to_len(imm);
  assign cap_wide = {{PAD_W{1'b0}}, cur_max};
  assign reg_over = (src_rdata > cap_wide);
  assign reg_len  = reg_over ? cur_max : src_rdata[LEN_W-1:0];

  always_comb begin
    nxt_max = cur_max;
    nxt_vl  = cur_vl;
    upd     = 1'b1;
    unique case (op)
      OP_LOOP_IMM: nxt_vl = min_len(imm_len, cur_max);
      OP_LOOP_REG: nxt_vl = reg_len;
      OP_SET_BOTH: begin
        nxt_max = imm_len;
        nxt_vl  = imm_len;
      end
      OP_SET_MAX: begin
        nxt_max = imm_len;
        nxt_vl  = min_len(cur_vl, imm_len);
      end
      default: upd = 1'b0;
    endcase
  end

endmodule

// File: rtl/vlc_regs.sv
module vlc_regs
  import vlc_pkg::*;
#(
  parameter int RESET_LEN = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic [LEN_W-1:0] nxt_max,
  input  logic [LEN_W-1:0] nxt_vl,
  output logic [LEN_W-1:0] maxvl_q,
  output logic [LEN_W-1:0] vl_q
);

  localparam logic [LEN_W-1:0] RST_V = LEN_W'(RESET_LEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      maxvl_q <= RST_V;
      vl_q    <= RST_V;
    end else if (upd) begin
      maxvl_q <= nxt_max;
      vl_q    <= nxt_vl;
    end
  end

endmodule

// File: rtl/vlc_wb.sv
module vlc_wb
  import vlc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic             upd,
  input  logic [IDX_W-1:0] dest,
  input  logic [LEN_W-1:0] nxt_vl,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_addr,
  output logic [XLEN-1:0]  wr_data
);

  localparam int PAD_W = XLEN - LEN_W;

  assign wr_en   = upd && (dest != '0);
  assign wr_addr = dest;
  assign wr_data = {{PAD_W{1'b0}}, nxt_vl};

endmodule

// File: rtl/vl_ctrl_unit.sv
module vl_ctrl_unit
  import vlc_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int RESET_LEN = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  input  logic [FIELD_W-1:0] vl_field,
  input  logic [XLEN-1:0]    src_rdata,
  output logic [IDX_W-1:0]   src_addr,
  output logic [LEN_W-1:0]   maxvl,
  output logic [LEN_W-1:0]   vl,
  output logic               wr_en,
  output logic [IDX_W-1:0]   wr_addr,
  output logic [XLEN-1:0]    wr_data
);

  vl_cmd_t          cmd;
  logic             is_noop;
  logic             upd_en;
  logic [LEN_W-1:0] nxt_max;
  logic [LEN_W-1:0] nxt_vl;

  assign src_addr = vl_field[IMM_HI:IMM_LO];

  vlc_decode u_decode (
    .valid   (instr_valid),
    .field   (vl_field),
    .cmd     (cmd),
    .is_noop (is_noop)
  );

  vlc_next #(.XLEN(XLEN)) u_next (
    .op        (cmd.op),
    .imm       (cmd.imm),
    .cur_max   (maxvl),
    .cur_vl    (vl),
    .src_rdata (src_rdata),
    .nxt_max   (nxt_max),
    .nxt_vl    (nxt_vl),
    .upd       (upd_en)
  );

  vlc_regs #(.RESET_LEN(RESET_LEN)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd     (upd_en),
    .nxt_max (nxt_max),
    .nxt_vl  (nxt_vl),
    .maxvl_q (maxvl),
    .vl_q    (vl)
  );

  vlc_wb #(.XLEN(XLEN)) u_wb (
    .upd     (upd_en),
    .dest    (cmd.dest),
    .nxt_vl  (nxt_vl),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

endmodule

// File: rtl/vl_ctrl_unit_chk.sv
module vl_ctrl_unit_chk
  import vlc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               instr_valid,
  input logic [FIELD_W-1:0] vl_field,
  input logic [LEN_W-1:0]   maxvl,
  input logic [LEN_W-1:0]   vl,
  input logic               wr_en,
  input logic [IDX_W-1:0]   wr_addr,
  input logic [XLEN-1:0]    wr_data,
  input logic               is_noop,
  input logic               upd_en
);

  // R9: no strobe, no change
  a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> ($stable(maxvl) && $stable(vl)));

  // R2: all-zero field leaves state and raises no write
  a_r2_zero_noop: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && is_noop) |-> (!wr_en && !upd_en));

  // R3: one-off both -> equal registers
  a_r3_both_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && vl_field[MODE_BIT] && !vl_field[FLAG_BIT]) |=> (maxvl == vl));

  // R4: ceiling-only keeps vl within the ceiling
  a_r4_vl_fits: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && vl_field[MODE_BIT] && vl_field[FLAG_BIT]) |=> (vl <= maxvl));

  // R5: loop immediate leaves ceiling alone
  a_r5_loop_keeps_max: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !vl_field[MODE_BIT] && vl_field[FLAG_BIT]) |=>
    ($stable(maxvl) && (vl <= maxvl)));

  // R7: a write only happens for a strobed field
  a_r7_write_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (instr_valid && upd_en));

  // R7: written value is what vl becomes
  a_r7_write_matches_vl: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (vl == $past(wr_data[LEN_W-1:0])));

  // R8: destination zero never written
  a_r8_no_x0_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_addr == '0) |-> !wr_en);

endmodule

bind vl_ctrl_unit vl_ctrl_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_valid (instr_valid),
  .vl_field    (vl_field),
  .maxvl       (maxvl),
  .vl          (vl),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .is_noop     (is_noop),
  .upd_en      (upd_en)
);

// File: tb/vl_ctrl_unit_tb.sv
module vl_ctrl_unit_tb;

  localparam int XLEN = 64;
  localparam int NV   = 13;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             instr_valid = 1'b0;
  logic [11:0]      vl_field = '0;
  logic [XLEN-1:0]  src_rdata = '0;
  logic [4:0]       src_addr;
  logic [5:0]       maxvl;
  logic [5:0]       vl;
  logic             wr_en;
  logic [4:0]       wr_addr;
  logic [XLEN-1:0]  wr_data;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  vl_ctrl_unit #(.XLEN(XLEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .vl_field(vl_field),
    .src_rdata(src_rdata), .src_addr(src_addr), .maxvl(maxvl), .vl(vl),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  // {valid, mode, dest, imm, flag, regval16, exp_max, exp_vl, exp_we, exp_waddr, exp_wdata}
  localparam logic [52:0] VEC [NV] = '{
    {1'b1, 1'b1,5'd3, 5'd15,1'b0, 16'd0,   6'd16,6'd16, 1'b1,5'd3, 6'd16}, // R3 R7
    {1'b1, 1'b0,5'd4, 5'd7, 1'b1, 16'd0,   6'd16,6'd8,  1'b1,5'd4, 6'd8 }, // R5
    {1'b1, 1'b0,5'd5, 5'd31,1'b1, 16'd0,   6'd16,6'd16, 1'b1,5'd5, 6'd16}, // R5 clamp
    {1'b1, 1'b0,5'd6, 5'd9, 1'b0, 16'd5,   6'd16,6'd5,  1'b1,5'd6, 6'd5 }, // R6
    {1'b1, 1'b0,5'd6, 5'd9, 1'b0, 16'd300, 6'd16,6'd16, 1'b1,5'd6, 6'd16}, // R6 wide
    {1'b1, 1'b1,5'd7, 5'd9, 1'b1, 16'd0,   6'd10,6'd10, 1'b1,5'd7, 6'd10}, // R4 shrink
    {1'b1, 1'b0,5'd0, 5'd2, 1'b1, 16'd0,   6'd10,6'd3,  1'b0,5'd0, 6'd0 }, // R8
    {1'b1, 1'b1,5'd1, 5'd19,1'b1, 16'd0,   6'd20,6'd3,  1'b1,5'd1, 6'd3 }, // R4 grow
    {1'b1, 1'b0,5'd0, 5'd0, 1'b0, 16'd7,   6'd20,6'd3,  1'b0,5'd0, 6'd0 }, // R2
    {1'b0, 1'b1,5'd2, 5'd5, 1'b0, 16'd0,   6'd20,6'd3,  1'b0,5'd0, 6'd0 }, // R9
    {1'b1, 1'b1,5'd0, 5'd31,1'b0, 16'd0,   6'd32,6'd32, 1'b0,5'd0, 6'd0 }, // R3 R8
    {1'b1, 1'b0,5'd2, 5'd3, 1'b0, 16'd0,   6'd32,6'd0,  1'b1,5'd2, 6'd0 }, // R6 zero
    {1'b1, 1'b1,5'd31,5'd0, 1'b0, 16'd0,   6'd1, 6'd1,  1'b1,5'd31,6'd1 }  // R3 R7
  };

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", "maxvl", 64'(maxvl), 64'd1);
    check("R1", "vl", 64'(vl), 64'd1);
    check("R1", "wr_en", 64'(wr_en), 64'd0);

    for (int i = 0; i < NV; i++) begin
      logic [52:0] v;
      v = VEC[i];
      @(negedge clk);
      instr_valid = v[52];
      vl_field    = v[51:40];
      src_rdata   = XLEN'(v[39:24]);
      #1;
      check("R7", $sformatf("wr_en vec%0d", i), 64'(wr_en), 64'(v[11]));
      if (v[11]) begin
        check("R7", $sformatf("wr_addr vec%0d", i), 64'(wr_addr), 64'(v[10:6]));
        check("R7", $sformatf("wr_data vec%0d", i), wr_data, 64'(v[5:0]));
      end
      @(posedge clk);
      #1;
      check("R3-5", $sformatf("maxvl vec%0d", i), 64'(maxvl), 64'(v[23:18]));
      check("R3-6", $sformatf("vl vec%0d", i), 64'(vl), 64'(v[17:12]));
    end

    // R6: read address follows bits 5:1
    @(negedge clk);
    instr_valid = 1'b0;
    vl_field = {1'b0, 5'd0, 5'd22, 1'b0};
    #1;
    check("R6", "src_addr", 64'(src_addr), 64'd22);

    // R1: reset mid-run restores both registers
    rst_n = 1'b0;
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "maxvl after reset", 64'(maxvl), 64'd1);
    check("R1", "vl after reset", 64'(vl), 64'd1);

    // R5: loop request above reset ceiling stays at 1
    instr_valid = 1'b1;
    vl_field = {1'b0, 5'd9, 5'd4, 1'b1};
    @(posedge clk);
    #1;
    check("R5", "vl clamped to 1", 64'(vl), 64'd1);
    instr_valid = 1'b0;

    finish_run();
  end

endmodule